// File: doc/BRIEF.md
# Speed-Mode Clock Configuration Controller

This block converts a host's bus-speed request into the settings a card clock path needs. A request carries a bus mode (single data rate, double data rate, or the strobed 8-bit double-rate mode referred to here as HS400), a flag saying the data bus is 8 bits wide, and the card clock frequency the host wants. From these the block picks one of three programmed timing words and merges it into a clock-select register. It sets or clears the data-strobe enable and the read-strobe delay, and works out the rate an external clock generator has to produce.

The generator is reached over a valid/acknowledge handshake. The block holds the requested rate until the generator acknowledges and returns the rate it actually reached. The block then latches that rate divided by the clock divider as the resulting bus rate. Software programs the timing words, the tuned sample phase and the strobe delay through a small register port. The same port reads back the clock-select register, the strobe state and the bus rate.

Top module: `speed_clk_cfg`

## Requirements
- R1: The timing word used is chosen by mode code: 2 (HS400) uses the HS400 word with its sample-phase field (bits [2:0]) replaced by the stored tuned phase; 1 uses the DDR word; 0 and 3 use the SDR word.
- R2: A request replaces only the timing fields of the clock-select register (address 0): sample phase [2:0], drive phase [6:4] and divider [10:8]. Every other bit keeps its value, and bits of a timing word outside those fields are never copied.
- R3: The wanted frequency is doubled in HS400 mode, doubled in DDR mode only when the 8-bit flag is set, and never doubled in SDR mode.
- R4: A request whose wanted frequency is zero issues no rate request and leaves the bus rate unchanged. Its timing and strobe settings are still applied.
- R5: A nonzero wanted frequency below MIN_FREQ is raised to MIN_FREQ before use.
- R6: When the clamped frequency equals the last applied frequency, no rate request is issued.
- R7: The requested rate is the clamped frequency times the divider value, which is the divider field of the newly merged clock-select word plus one.
- R8: rateValid stays high with a stable rateReq until rateAck. On the acknowledging edge busRate becomes rateActual divided by the divider value. Requests that arrive while rateValid is high are ignored.
- R9: An HS400 request sets strobeEn and loads rdDelay from the programmed delay (address 5). Any other mode clears strobeEn and leaves rdDelay unchanged.
- R10: holdBypass is high exactly when the drive-phase field [6:4] of the clock-select register is zero.
- R11: Reset clears every register, so holdBypass is high, strobeEn, rateValid and busRate are low, and the first nonzero request after reset always issues a rate request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle speed request strobe |
| reqMode | input | 2 | Bus mode: 0 SDR, 1 DDR, 2 HS400, 3 SDR |
| reqWidth8 | input | 1 | Data bus is 8 bits wide |
| reqFreq | input | FREQ_W | Wanted card clock frequency |
| regWr | input | 1 | Register write enable |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| rateValid | output | 1 | Rate request to the clock generator is pending |
| rateReq | output | FREQ_W+4 | Generator rate requested |
| rateAck | input | 1 | Generator accepted the request |
| rateActual | input | FREQ_W+4 | Rate the generator reached |
| busRate | output | FREQ_W+4 | Generator rate divided by the divider value |
| strobeEn | output | 1 | Data-strobe enable |
| rdDelay | output | 8 | Read-strobe delay field |
| holdBypass | output | 1 | Bypass hold stage for command and data |

## Verification
A single programmed configuration is driven with a chain of requests that visits every mode code with both bus-width flags. Each timing word has a different divider and drive phase, so the register readback, rateReq and holdBypass show which word was merged and whether junk bits leaked in. Frequencies are ordered so that a doubled or clamped value lands exactly on the last applied frequency. This separates the doubling rules from the repeat suppression, and a zero request checks that the clock is left alone. Directed cases then send a request while the generator has not yet acknowledged, and send a first request after reset that matches no earlier frequency.

// File: rtl/speed_clk_pkg.sv
package speed_clk_pkg;

  typedef enum logic [1:0] {
    MODE_SDR   = 2'd0,
    MODE_DDR   = 2'd1,
    MODE_HS400 = 2'd2,
    MODE_RSVD  = 2'd3
  } busMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic applyReq;
    logic startRate;
    logic finishRate;
  } ctlStrobe_t;

  localparam int REG_W   = 32;
  localparam int REG_AW  = 3;
  localparam int FIELD_W = 3;
  localparam int SMPL_LSB = 0;
  localparam int DRV_LSB  = 4;
  localparam int DIV_LSB  = 8;

  localparam logic [REG_AW-1:0] ADDR_CLKSEL = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_SDR    = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_DDR    = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_HS4    = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_TUNE   = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_DLY    = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_STROBE = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_RATE   = 3'd7;

endpackage

// File: rtl/speed_clk_ctrl.sv
module speed_clk_ctrl
  import speed_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       needRate,
  input  logic       rateAck,
  output ctlStrobe_t strobe,
  output logic       rateValid
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.applyReq = 1'b1;
        if (needRate) begin
          strobe.startRate = 1'b1;
          stateNxt = ST_WAIT;
        end
      end
      ST_WAIT: if (rateAck) begin
        strobe.finishRate = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign rateValid = (state == ST_WAIT);

endmodule

// File: rtl/speed_clk_dp.sv
module speed_clk_dp
  import speed_clk_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int MIN_FREQ = 400,
  parameter int DLY_W    = 8,
  localparam int WANT_W  = FREQ_W + 1,
  localparam int DIVV_W  = FIELD_W + 1,
  localparam int RATE_W  = WANT_W + FIELD_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        reqMode,
  input  logic              reqWidth8,
  input  logic [FREQ_W-1:0] reqFreq,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [RATE_W-1:0] rateActual,
  output logic              needRate,
  output logic [RATE_W-1:0] rateReq,
  output logic [RATE_W-1:0] busRate,
  output logic              strobeEn,
  output logic [DLY_W-1:0]  rdDelay,
  output logic              holdBypass
);

  localparam logic [REG_W-1:0] FIELD_ONES = REG_W'((1 << FIELD_W) - 1);
  localparam logic [REG_W-1:0] SMPL_MASK  = FIELD_ONES << SMPL_LSB;
  localparam logic [REG_W-1:0] TIMING_MASK =
    (FIELD_ONES << SMPL_LSB) | (FIELD_ONES << DRV_LSB) | (FIELD_ONES << DIV_LSB);
  localparam logic [WANT_W-1:0] MIN_W = WANT_W'(MIN_FREQ);

  logic [REG_W-1:0]   clkSel, sdrWord, ddrWord, hs4Word;
  logic [FIELD_W-1:0] tunedPhase;
  logic [DLY_W-1:0]   cfgDelay;
  logic [WANT_W-1:0]  lastFreq;
  logic [DIVV_W-1:0]  pendDiv;
  logic [WANT_W-1:0]  pendFreq;

  busMode_e           modeSel;
  logic [REG_W-1:0]   selWord, mergedSel;
  logic [DIVV_W-1:0]  newDiv;
  logic               dbl;
  logic [WANT_W-1:0]  wanted, clamped;

  assign modeSel = busMode_e'(reqMode);

  always_comb begin
    case (modeSel)
      MODE_HS400: begin
        selWord = (hs4Word & ~SMPL_MASK) | (REG_W'(tunedPhase) << SMPL_LSB);
        dbl     = 1'b1;
      end
      MODE_DDR: begin
        selWord = ddrWord;
        dbl     = reqWidth8;
      end
      default: begin
        selWord = sdrWord;
        dbl     = 1'b0;
      end
    endcase
  end

  assign mergedSel = (clkSel & ~TIMING_MASK) | (selWord & TIMING_MASK);
  assign newDiv    = {1'b0, mergedSel[DIV_LSB +: FIELD_W]} + DIVV_W'(1);
  assign wanted    = dbl ? {reqFreq, 1'b0} : {1'b0, reqFreq};
  assign clamped   = (wanted < MIN_W) ? MIN_W : wanted;
  assign needRate  = (wanted != '0) && (clamped != lastFreq);

  // configuration and clock-select registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel     <= '0;
      sdrWord    <= '0;
      ddrWord    <= '0;
      hs4Word    <= '0;
      tunedPhase <= '0;
      cfgDelay   <= '0;
      strobeEn   <= 1'b0;
      rdDelay    <= '0;
    end else begin
      if (regWr) begin
        case (regAddr)
          ADDR_CLKSEL: clkSel     <= regWdata;
          ADDR_SDR:    sdrWord    <= regWdata;
          ADDR_DDR:    ddrWord    <= regWdata;
          ADDR_HS4:    hs4Word    <= regWdata;
          ADDR_TUNE:   tunedPhase <= regWdata[FIELD_W-1:0];
          ADDR_DLY:    cfgDelay   <= regWdata[DLY_W-1:0];
          default: ;
        endcase
      end
      if (strobe.applyReq) begin
        clkSel <= mergedSel;
        if (modeSel == MODE_HS400) begin
          strobeEn <= 1'b1;
          rdDelay  <= cfgDelay;
        end else begin
          strobeEn <= 1'b0;
        end
      end
    end
  end

  // rate request path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastFreq <= '0;
      pendFreq <= '0;
      pendDiv  <= DIVV_W'(1);
      rateReq  <= '0;
      busRate  <= '0;
    end else begin
      if (strobe.startRate) begin
        pendFreq <= clamped;
        pendDiv  <= newDiv;
        rateReq  <= RATE_W'(clamped) * RATE_W'(newDiv);
      end
      if (strobe.finishRate) begin
        lastFreq <= pendFreq;
        busRate  <= rateActual / RATE_W'(pendDiv);
      end
    end
  end

  assign holdBypass = (clkSel[DRV_LSB +: FIELD_W] == '0);

  always_comb begin
    case (regAddr)
      ADDR_CLKSEL: regRdata = clkSel;
      ADDR_SDR:    regRdata = sdrWord;
      ADDR_DDR:    regRdata = ddrWord;
      ADDR_HS4:    regRdata = hs4Word;
      ADDR_TUNE:   regRdata = REG_W'(tunedPhase);
      ADDR_DLY:    regRdata = REG_W'(cfgDelay);
      ADDR_STROBE: regRdata = REG_W'({rdDelay, strobeEn});
      default:     regRdata = REG_W'(busRate);
    endcase
  end

endmodule

// File: rtl/speed_clk_cfg.sv
module speed_clk_cfg
  import speed_clk_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int MIN_FREQ = 400,
  parameter int DLY_W    = 8,
  localparam int RATE_W  = FREQ_W + 1 + FIELD_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic              reqWidth8,
  input  logic [FREQ_W-1:0] reqFreq,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              rateValid,
  output logic [RATE_W-1:0] rateReq,
  input  logic              rateAck,
  input  logic [RATE_W-1:0] rateActual,
  output logic [RATE_W-1:0] busRate,
  output logic              strobeEn,
  output logic [DLY_W-1:0]  rdDelay,
  output logic              holdBypass
);

  ctlStrobe_t strobe;
  logic       needRate;

  speed_clk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .needRate  (needRate),
    .rateAck   (rateAck),
    .strobe    (strobe),
    .rateValid (rateValid)
  );

  speed_clk_dp #(
    .FREQ_W   (FREQ_W),
    .MIN_FREQ (MIN_FREQ),
    .DLY_W    (DLY_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqMode    (reqMode),
    .reqWidth8  (reqWidth8),
    .reqFreq    (reqFreq),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .rateActual (rateActual),
    .needRate   (needRate),
    .rateReq    (rateReq),
    .busRate    (busRate),
    .strobeEn   (strobeEn),
    .rdDelay    (rdDelay),
    .holdBypass (holdBypass)
  );

endmodule

// File: rtl/speed_clk_cfg_chk.sv
module speed_clk_cfg_chk
  import speed_clk_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int MIN_FREQ = 400,
  localparam int RATE_W  = FREQ_W + 1 + FIELD_W
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqMode,
  input logic [FREQ_W-1:0] reqFreq,
  input logic [REG_AW-1:0] regAddr,
  input logic [REG_W-1:0]  regRdata,
  input logic              rateValid,
  input logic              rateAck,
  input logic [RATE_W-1:0] rateReq,
  input logic              strobeEn,
  input logic              holdBypass
);

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid && !rateAck |=> rateValid && $stable(rateReq));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |=> $stable(strobeEn));

  // R6
  rate_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rateValid) |-> $past(reqValid) && ($past(reqFreq) != '0));

  // R5
  rate_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> rateReq >= RATE_W'(MIN_FREQ));

  // R9
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeEn) |-> $past(reqValid) && ($past(reqMode) == 2'd2));

  // R10
  hold_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CLKSEL) |-> holdBypass == (regRdata[DRV_LSB +: FIELD_W] == '0));

endmodule

bind speed_clk_cfg speed_clk_cfg_chk #(
  .FREQ_W   (FREQ_W),
  .MIN_FREQ (MIN_FREQ)
) u_chk (.*);

// File: tb/speed_clk_cfg_tb.sv
module speed_clk_cfg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 24;
  localparam int RATE_W = FREQ_W + 4;
  localparam int NV = 11;

  logic              clk = 0;
  logic              rstN = 0;
  logic              reqValid = 0;
  logic [1:0]        reqMode = 0;
  logic              reqWidth8 = 0;
  logic [FREQ_W-1:0] reqFreq = 0;
  logic              regWr = 0;
  logic [2:0]        regAddr = 0;
  logic [31:0]       regWdata = 0;
  logic [31:0]       regRdata;
  logic              rateValid;
  logic [RATE_W-1:0] rateReq;
  logic              rateAck = 0;
  logic [RATE_W-1:0] rateActual = 0;
  logic [RATE_W-1:0] busRate;
  logic              strobeEn;
  logic [7:0]        rdDelay;
  logic              holdBypass;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speed_clk_cfg u_dut (.*);

  // vector table: mode, width8, freq, expect rate, expect rateReq, actual, expect busRate, clksel, hold, strobe, delay
  localparam logic [1:0]  V_MODE [NV] = '{0, 0, 1, 1, 2, 2, 0, 3, 0, 1, 1};
  localparam logic        V_W8   [NV] = '{1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam int          V_FREQ [NV] = '{1000, 1000, 1000, 1000, 1000, 3000, 100, 400, 0, 150, 250};
  localparam logic        V_RV   [NV] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 1};
  localparam int          V_REQ  [NV] = '{2000, 0, 0, 8000, 0, 6000, 800, 0, 0, 0, 2000};
  localparam int          V_ACT  [NV] = '{2002, 0, 0, 8000, 0, 6000, 801, 0, 0, 0, 1999};
  localparam int          V_BUS  [NV] = '{1001, 1001, 1001, 2000, 2000, 6000, 400, 400, 400, 400, 499};
  localparam logic [31:0] V_SEL  [NV] = '{32'hABCD01A1, 32'hABCD01A1, 32'hABCD0383, 32'hABCD0383,
                                          32'hABCD0096, 32'hABCD0096, 32'hABCD01A1, 32'hABCD01A1,
                                          32'hABCD01A1, 32'hABCD0383, 32'hABCD0383};
  localparam logic        V_HOLD [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam logic        V_STB  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0};
  localparam logic [7:0]  V_DLY  [NV] = '{0, 0, 0, 0, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 0; regAddr = 0;
  endtask

  task automatic request(input logic [1:0] m, input logic w, input int f);
    @(negedge clk);
    reqValid = 1; reqMode = m; reqWidth8 = w; reqFreq = FREQ_W'(f);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic ack(input int a);
    rateAck = 1; rateActual = RATE_W'(a);
    @(negedge clk);
    rateAck = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    regAddr = 0;
    #1;
    chk("R11", "clksel", regRdata, 0);
    chk("R11", "holdBypass", 32'(holdBypass), 1);
    chk("R11", "strobeEn", 32'(strobeEn), 0);
    chk("R11", "rateValid", 32'(rateValid), 0);
    chk("R11", "busRate", 32'(busRate), 0);
    rstN = 1;

    wr(3'd0, 32'hABCD0080);
    wr(3'd1, 32'hF0000121);
    wr(3'd2, 32'h00000303);
    wr(3'd3, 32'h00000015);
    wr(3'd4, 32'h6);
    wr(3'd5, 32'h5A);

    for (int i = 0; i < NV; i++) begin
      request(V_MODE[i], V_W8[i], V_FREQ[i]);
      regAddr = 0;
      #1;
      // R1 R2 word selection and merge
      chk("R1/R2", $sformatf("clksel v%0d", i), regRdata, V_SEL[i]);
      // R10
      chk("R10", $sformatf("holdBypass v%0d", i), 32'(holdBypass), 32'(V_HOLD[i]));
      // R9
      chk("R9", $sformatf("strobeEn v%0d", i), 32'(strobeEn), 32'(V_STB[i]));
      chk("R9", $sformatf("rdDelay v%0d", i), 32'(rdDelay), 32'(V_DLY[i]));
      // R3 R4 R5 R6
      chk("R3/R4/R6", $sformatf("rateValid v%0d", i), 32'(rateValid), 32'(V_RV[i]));
      if (V_RV[i]) begin
        // R7 R5
        chk("R7/R5", $sformatf("rateReq v%0d", i), 32'(rateReq), V_REQ[i]);
        ack(V_ACT[i]);
        #1;
        chk("R8", $sformatf("rateValid after ack v%0d", i), 32'(rateValid), 0);
      end
      // R8 R4
      chk("R8/R4", $sformatf("busRate v%0d", i), 32'(busRate), V_BUS[i]);
    end

    // R8 request while generator busy is ignored
    request(2'd0, 1'b0, 700);
    #1;
    chk("R8", "busy rateReq", 32'(rateReq), 1400);
    request(2'd2, 1'b0, 5000);
    regAddr = 0;
    #1;
    chk("R8", "busy clksel kept", regRdata, 32'hABCD01A1);
    chk("R8", "busy strobe kept", 32'(strobeEn), 0);
    chk("R8", "busy rateValid held", 32'(rateValid), 1);
    chk("R8", "busy rateReq held", 32'(rateReq), 1400);
    ack(1400);
    #1;
    chk("R8", "busy busRate", 32'(busRate), 700);
    @(negedge clk);
    regAddr = 3'd7;
    #1;
    chk("R8", "busRate readback", regRdata, 700);

    // R11 reset then first request at a previously applied frequency
    rstN = 0;
    @(negedge clk);
    chk("R11", "busRate after reset", 32'(busRate), 0);
    rstN = 1;
    request(2'd0, 1'b0, 400);
    regAddr = 0;
    #1;
    chk("R11", "first request rateValid", 32'(rateValid), 1);
    chk("R11", "first request rateReq", 32'(rateReq), 400);
    ack(400);
    #1;
    chk("R11", "first request busRate", 32'(busRate), 400);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule